// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the single reservation of one hardware thread and settles the outcome of every store-conditional. A load-reserved reads a 32-bit word through a single-cycle memory port and returns it sign-extended to the register width. It also records a reservation over the naturally aligned 16-byte granule that holds the word. A store-conditional writes memory only while that reservation is live and covers the target word. It returns zero on success and one on failure, and it always drops the reservation.

A snoop-invalidate input reports that another agent has written the reserved data. It kills the reservation in the cycle it is asserted. The monitor never locks the bus. It only records which granule the thread holds exclusively. Plain stores pass straight through to memory.

The memory port reads combinationally in the same cycle and writes at the clock edge. The destination result is registered and appears one cycle after the operation.

Top module: `lrsc_monitor`

## Requirements
- R1: While reset is asserted and after it is released, rd_valid_o is low, rd_o is zero and no reservation is held, so a store-conditional issued first after reset fails.
- R2: A load-reserved (op_i = 1) reads the word at addr_i with bits 1:0 ignored. One cycle later rd_o holds that word sign-extended from bit 31 to XLEN bits.
- R3: A successful store-conditional (op_i = 2) writes wdata_i to the addressed word, and one cycle later rd_o is zero.
- R4: A store-conditional succeeds only if a reservation is valid, addr_i bits 1:0 are zero, and addr_i bits above bit 3 equal those of the reserved address. Any word of the reserved 16-byte granule qualifies.
- R5: Every store-conditional clears the reservation, whether it succeeds or fails.
- R6: While snoop_inv_i is high, the reservation is cleared. A store-conditional in the same cycle fails. A load-reserved in the same cycle returns its data but leaves no reservation.
- R7: A load-reserved replaces any held reservation with the granule of its own address.
- R8: A failed store-conditional performs no memory write and returns rd_o = 1. A store-conditional with addr_i bits 1:0 nonzero always fails.
- R9: A plain store (op_i = 3) always writes wdata_i to the word at addr_i with bits 1:0 ignored, and it leaves the reservation unchanged.
- R10: rd_valid_o is high for exactly the cycle after a load-reserved or store-conditional. It stays low after a plain store or idle (op_i = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 0 idle, 1 load-reserved, 2 store-conditional, 3 plain store |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Store data |
| snoop_inv_i | input | 1 | Invalidate from another agent |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, same cycle |
| rd_valid_o | output | 1 | Destination result valid |
| rd_o | output | XLEN | Loaded value or store-conditional status |

## Verification
The bench targets granule matching. It issues a store-conditional to a different word of the reserved granule, which must succeed, and one to a neighbouring granule, which must fail. A design that compared full word addresses, or too few bits, would get one of these wrong. It also checks that a failed store-conditional still kills the reservation and that a plain store does not. A design that cleared only on success, or on any write, would let a later conditional succeed wrongly or fail wrongly. Snoop timing is exercised in three ways: alone, together with a store-conditional, and together with a load-reserved. Misaligned conditionals and negative loaded words are checked for missing writes, stray writes and bad sign extension.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LR   = 2'd1,
    OP_SC   = 2'd2,
    OP_ST   = 2'd3
  } lrsc_op_e;

  localparam int unsigned WORD_W       = 32;
  localparam int unsigned SC_FAIL_CODE = 1;
endpackage

// File: rtl/lrsc_addr_dec.sv
module lrsc_addr_dec #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned GRAN_LSB = 4,
  localparam int unsigned TAG_W   = ADDR_W - GRAN_LSB
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TAG_W-1:0]  resv_tag_i,
  input  logic              resv_vld_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              aligned_o,
  output logic              hit_o
);
  assign word_addr_o = {addr_i[ADDR_W-1:2], 2'b00};
  assign tag_o       = addr_i[ADDR_W-1:GRAN_LSB];
  assign aligned_o   = (addr_i[1:0] == 2'b00);
  // an aligned word never straddles a granule, so the tag compare covers all its bytes
  assign hit_o       = resv_vld_i && (tag_o == resv_tag_i);
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             vld_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             vld_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tag_q <= '0;
    end else begin
      if (clr_i)      vld_q <= 1'b0;  // snoop or SC wins over a new LR
      else if (set_i) vld_q <= 1'b1;
      if (set_i)      tag_q <= tag_i;
    end
  end

  assign vld_o = vld_q;
  assign tag_o = tag_q;
endmodule

// File: rtl/lrsc_result.sv
module lrsc_result #(
  parameter int unsigned XLEN = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        lr_i,
  input  logic                        sc_i,
  input  logic                        sc_ok_i,
  input  logic [lrsc_pkg::WORD_W-1:0] rdata_i,
  output logic                        rd_valid_o,
  output logic [XLEN-1:0]             rd_o
);
  import lrsc_pkg::*;

  logic [XLEN-1:0] sext;
  logic [XLEN-1:0] rd_d;
  logic            vld_q;
  logic [XLEN-1:0] rd_q;

  generate
    if (XLEN > WORD_W) begin : g_sext
      assign sext = {{(XLEN-WORD_W){rdata_i[WORD_W-1]}}, rdata_i};
    end else begin : g_flat
      assign sext = rdata_i[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    rd_d = rd_q;
    if (lr_i)      rd_d = sext;
    else if (sc_i) rd_d = sc_ok_i ? '0 : XLEN'(SC_FAIL_CODE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      vld_q <= lr_i | sc_i;
      rd_q  <= rd_d;
    end
  end

  assign rd_valid_o = vld_q;
  assign rd_o       = rd_q;
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned XLEN     = 64,
  parameter int unsigned GRAN_LSB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              snoop_inv_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              rd_valid_o,
  output logic [XLEN-1:0]   rd_o
);
  import lrsc_pkg::*;

  localparam int unsigned TAG_W = ADDR_W - GRAN_LSB;

  lrsc_op_e         op;
  logic             is_lr, is_sc, is_st;
  logic [TAG_W-1:0] addr_tag, resv_tag;
  logic             resv_vld, aligned, hit, sc_ok;

  assign op    = lrsc_op_e'(op_i);
  assign is_lr = (op == OP_LR);
  assign is_sc = (op == OP_SC);
  assign is_st = (op == OP_ST);

  lrsc_addr_dec #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) i_dec (
    .addr_i     (addr_i),
    .resv_tag_i (resv_tag),
    .resv_vld_i (resv_vld),
    .word_addr_o(mem_addr_o),
    .tag_o      (addr_tag),
    .aligned_o  (aligned),
    .hit_o      (hit)
  );

  lrsc_resv #(.TAG_W(TAG_W)) i_resv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (is_lr),
    .clr_i (is_sc | snoop_inv_i),
    .tag_i (addr_tag),
    .vld_o (resv_vld),
    .tag_o (resv_tag)
  );

  assign sc_ok       = is_sc && hit && aligned && !snoop_inv_i;
  assign mem_we_o    = is_st | sc_ok;
  assign mem_wdata_o = wdata_i;

  lrsc_result #(.XLEN(XLEN)) i_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lr_i      (is_lr),
    .sc_i      (is_sc),
    .sc_ok_i   (sc_ok),
    .rdata_i   (mem_rdata_i),
    .rd_valid_o(rd_valid_o),
    .rd_o      (rd_o)
  );
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      op_i,
  input logic [1:0]      addr_lo,
  input logic            snoop_inv_i,
  input logic            mem_we_o,
  input logic            resv_vld,
  input logic            rd_valid_o,
  input logic [XLEN-1:0] rd_o
);
  p_sc_ok_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd2 && mem_we_o) |=> (rd_valid_o && rd_o == '0));

  p_sc_fail_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd2 && !mem_we_o) |=> (rd_valid_o && rd_o == XLEN'(1)));

  p_misalign_nowrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd2 && addr_lo != 2'b00) |-> !mem_we_o);

  p_sc_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd2) |=> !resv_vld);

  p_snoop_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_inv_i |=> !resv_vld);

  p_snoop_sc_nowrite_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd2 && snoop_inv_i) |-> !mem_we_o);

  p_valid_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ($past(op_i) == 2'd1 || $past(op_i) == 2'd2));

  p_lr_sext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(op_i) == 2'd1) |-> ((&rd_o[XLEN-1:31]) || !(|rd_o[XLEN-1:31])));
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.XLEN(XLEN)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .addr_lo    (addr_i[1:0]),
  .snoop_inv_i(snoop_inv_i),
  .mem_we_o   (mem_we_o),
  .resv_vld   (resv_vld),
  .rd_valid_o (rd_valid_o),
  .rd_o       (rd_o)
);

// File: tb/test_lrsc_monitor.sv
module test_lrsc_monitor;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned DEPTH  = 1 << (ADDR_W - 2);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        op = 2'd0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic              inv = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [31:0]       mem_wdata, mem_rdata;
  logic              rd_valid;
  logic [XLEN-1:0]   rd;

  logic [31:0] mem [DEPTH];
  int n_tests = 0;
  int n_fail  = 0;
  logic            got_vld;
  logic [XLEN-1:0] got_rd;

  always #5 clk = ~clk;

  always @(posedge clk) if (mem_we) mem[mem_addr[ADDR_W-1:2]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[ADDR_W-1:2]];

  lrsc_monitor #(.ADDR_W(ADDR_W), .XLEN(XLEN)) i_lrsc_monitor (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .addr_i(addr), .wdata_i(wdata),
    .snoop_inv_i(inv), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .rd_valid_o(rd_valid), .rd_o(rd)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, result registered at the next posedge, sampled at the following negedge
  task automatic do_op(input logic [1:0] o, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d, input logic v);
    @(negedge clk);
    op = o; addr = a; wdata = d; inv = v;
    @(negedge clk);
    got_vld = rd_valid; got_rd = rd;
    op = 2'd0; inv = 1'b0;
  endtask

  function automatic logic [31:0] peek(input logic [ADDR_W-1:0] a);
    return mem[a[ADDR_W-1:2]];
  endfunction

  task automatic t_reset;
    check("R1 rd_valid", XLEN'(rd_valid), 0);
    check("R1 rd", rd, 0);
    do_op(2'd2, 12'h010, 32'hDEAD0001, 1'b0);
    check("R1 sc after reset fails", got_rd, 1);
    check("R1 no write", XLEN'(peek(12'h010)), 0);
  endtask

  task automatic t_lr_sext;
    mem[12'h014 >> 2] = 32'h8000_1234;
    do_op(2'd1, 12'h016, 0, 1'b0);
    check("R2 lr valid", XLEN'(got_vld), 1);
    check("R2 lr negative", got_rd, 64'hFFFF_FFFF_8000_1234);
    mem[12'h018 >> 2] = 32'h7FFF_0042;
    do_op(2'd1, 12'h018, 0, 1'b0);
    check("R2 lr positive", got_rd, 64'h0000_0000_7FFF_0042);
  endtask

  task automatic t_sc_basic;
    do_op(2'd1, 12'h020, 0, 1'b0);
    do_op(2'd2, 12'h020, 32'hA5A5_0001, 1'b0);
    check("R3 sc result", got_rd, 0);
    check("R3 sc valid", XLEN'(got_vld), 1);
    check("R3 sc write", XLEN'(peek(12'h020)), XLEN'(32'hA5A5_0001));
    do_op(2'd2, 12'h020, 32'h1111_1111, 1'b0);
    check("R5 second sc fails", got_rd, 1);
    check("R8 no write on fail", XLEN'(peek(12'h020)), XLEN'(32'hA5A5_0001));
  endtask

  task automatic t_granule;
    do_op(2'd1, 12'h040, 0, 1'b0);
    do_op(2'd2, 12'h04C, 32'h0000_BEEF, 1'b0);
    check("R4 same granule ok", got_rd, 0);
    check("R4 same granule write", XLEN'(peek(12'h04C)), XLEN'(32'h0000_BEEF));
    do_op(2'd1, 12'h060, 0, 1'b0);
    do_op(2'd2, 12'h070, 32'h2222_2222, 1'b0);
    check("R4 other granule fails", got_rd, 1);
    check("R8 other granule no write", XLEN'(peek(12'h070)), 0);
    do_op(2'd2, 12'h060, 32'h3333_3333, 1'b0);
    check("R5 failed sc cleared resv", got_rd, 1);
  endtask

  task automatic t_snoop;
    do_op(2'd1, 12'h080, 0, 1'b0);
    do_op(2'd0, 12'h000, 0, 1'b1);
    do_op(2'd2, 12'h080, 32'h4444_4444, 1'b0);
    check("R6 snoop then sc fails", got_rd, 1);
    do_op(2'd1, 12'h090, 0, 1'b0);
    do_op(2'd2, 12'h090, 32'h5555_5555, 1'b1);
    check("R6 snoop with sc fails", got_rd, 1);
    check("R6 snoop with sc no write", XLEN'(peek(12'h090)), 0);
    mem[12'h0A0 >> 2] = 32'h0000_0077;
    do_op(2'd1, 12'h0A0, 0, 1'b1);
    check("R6 lr data with snoop", got_rd, 64'h77);
    do_op(2'd2, 12'h0A0, 32'h6666_6666, 1'b0);
    check("R6 lr with snoop leaves no resv", got_rd, 1);
  endtask

  task automatic t_replace;
    do_op(2'd1, 12'h0C0, 0, 1'b0);
    do_op(2'd1, 12'h0E0, 0, 1'b0);
    do_op(2'd2, 12'h0C0, 32'h7777_7777, 1'b0);
    check("R7 old granule fails", got_rd, 1);
    do_op(2'd1, 12'h0C0, 0, 1'b0);
    do_op(2'd1, 12'h0E0, 0, 1'b0);
    do_op(2'd2, 12'h0E4, 32'h8888_8888, 1'b0);
    check("R7 new granule ok", got_rd, 0);
  endtask

  task automatic t_misalign;
    do_op(2'd1, 12'h100, 0, 1'b0);
    do_op(2'd2, 12'h102, 32'h9999_9999, 1'b0);
    check("R8 misaligned fails", got_rd, 1);
    check("R8 misaligned no write", XLEN'(peek(12'h100)), 0);
    do_op(2'd2, 12'h100, 32'h9999_9999, 1'b0);
    check("R5 misaligned sc cleared resv", got_rd, 1);
  endtask

  task automatic t_store;
    do_op(2'd1, 12'h120, 0, 1'b0);
    do_op(2'd3, 12'h127, 32'hCAFE_0003, 1'b0);
    check("R10 no valid after store", XLEN'(got_vld), 0);
    check("R9 store write", XLEN'(peek(12'h124)), XLEN'(32'hCAFE_0003));
    do_op(2'd3, 12'h120, 32'hCAFE_0000, 1'b0);
    do_op(2'd0, 12'h120, 0, 1'b0);
    check("R10 no valid after idle", XLEN'(got_vld), 0);
    do_op(2'd2, 12'h120, 32'hCAFE_1111, 1'b0);
    check("R9 store keeps resv", got_rd, 0);
    check("R3 sc over store", XLEN'(peek(12'h120)), XLEN'(32'hCAFE_1111));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 rd_valid in reset", XLEN'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lr_sext();
    t_sc_basic();
    t_granule();
    t_snoop();
    t_replace();
    t_misalign();
    t_store();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule